// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines, holds each request until the processor takes it, and raises a single interrupt line toward the processor whenever an unmasked pending request is entitled to interrupt the work already under way. A mask register keeps chosen lines away from the arbitration. An in-service register remembers every level whose handler has started and not yet finished, so that a lower-ranked request cannot interrupt a higher-ranked handler.

The processor reaches the controller through a small byte-wide port. The address bit selects between the mask register and the command path. Commands choose one of three priority orderings: fixed, with level 0 highest; rotating, where a level that has just finished service drops to the bottom; and software-pinned, where software names the bottom level and the other levels follow it in circular order. When the processor answers the interrupt with an acknowledge pulse, the controller moves the winning request into service and presents its index. An end-of-service command retires the highest-ranked level in service.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the request, in-service and mask registers are all zero, the ordering is fixed, `int_out` is low, `ack_idx` is 0, and a command-path read returns the request register.
- R2: A request line that is high at a rising clock edge sets its bit in the request register, and that bit stays set after the line drops until an acknowledge takes it.
- R3: A write with `a0`=1 loads `wdata[7:0]` into the mask register (bit i masks line i); a read with `a0`=1 returns the mask; a masked request stays in the request register but cannot raise `int_out`.
- R4: Opcode `wdata[7:5]`=3'b011 (command path, `a0`=0) selects fixed ordering, in which level 0 ranks highest and level 7 lowest.
- R5: `int_out` is high exactly when the highest-ranked unmasked pending request ranks above every level in service (or nothing is in service).
- R6: An `ack` pulse sampled while `int_out` is high clears the winner's request bit, sets its in-service bit and loads its index into `ack_idx`, all visible one cycle later; an `ack` sampled while `int_out` is low changes nothing.
- R7: Opcode 3'b001 is end-of-service: it clears the highest-ranked set in-service bit, and does nothing if none is set.
- R8: Opcode 3'b100 selects rotating ordering, starting with level 7 lowest; in this ordering each end-of-service that clears a level makes that level the lowest.
- R9: Opcode 3'b101 selects pinned ordering with `wdata[2:0]` as the lowest level and the rest following circularly from it (lowest+1 highest); end-of-service does not move it.
- R10: Opcode 3'b010 selects what a command-path read returns: `wdata[0]`=0 the request register, 1 the in-service register.
- R11: With `cs` low, writes have no effect and `rdata` reads as zero.
- R12: Command-path writes with opcodes 3'b000, 3'b110 and 3'b111 leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Select; qualifies every access |
| wr | input | 1 | Write strobe, one cycle per write |
| a0 | input | 1 | Address bit: 1 mask register, 0 command path |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from address and state |
| irq_in | input | 8 | Request lines, active high |
| ack | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| ack_idx | output | 3 | Index of the last acknowledged level |

## Verification
Every register update lands at the rising edge that samples the stimulus, and `int_out` and `rdata` follow combinationally from the registers, so a request, mask write, command or acknowledge shows its effect one edge after it is driven. The bench drives all inputs just after a falling edge and samples one falling edge later, which places each check exactly one register stage after its cause; reads need no edge at all and are sampled a nanosecond after the address is set. Expected request, in-service, mask and lowest-level values come from a bench model updated per step, and whole request patterns are drained in each ordering to compare every acknowledged index.

// File: rtl/pic_pkg.sv
// Package: shared encodings for the priority interrupt controller.
// Assumes the command opcode sits in the top three bits of the write byte.
package pic_pkg;

    typedef enum logic [1:0] {
        PM_FIXED    = 2'd0,
        PM_ROTATE   = 2'd1,
        PM_PINNED   = 2'd2
    } prio_mode_e;

    localparam logic [2:0] OP_END_SERVICE = 3'b001;
    localparam logic [2:0] OP_READ_SELECT = 3'b010;
    localparam logic [2:0] OP_SET_FIXED   = 3'b011;
    localparam logic [2:0] OP_SET_ROTATE  = 3'b100;
    localparam logic [2:0] OP_SET_PINNED  = 3'b101;

    localparam logic READ_REQ = 1'b0;
    localparam logic READ_SVC = 1'b1;

endpackage

// File: rtl/pic_prio_pick.sv
// Module: pic_prio_pick
// Finds the highest-ranked set bit of a vector under a circular order whose
// bottom is `lowest`; rank 0 is the level just above `lowest`.
// Assumes `lowest` < LEVELS. Purely combinational.
module pic_prio_pick #(
    parameter int unsigned LEVELS = 8,
    localparam int unsigned IW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [LEVELS-1:0] vec,
    input  logic [IW-1:0]     lowest,
    output logic              found,
    output logic [IW-1:0]     idx,
    output logic [IW-1:0]     rank
);

    // Scan ranks from worst to best so the best set level is kept last.
    always_comb begin
        int lvl;
        found = 1'b0;
        idx   = '0;
        rank  = '0;
        for (int r = LEVELS - 1; r >= 0; r--) begin
            lvl = (int'(lowest) + 1 + r) % LEVELS;
            if (vec[lvl]) begin
                found = 1'b1;
                idx   = IW'(lvl);
                rank  = IW'(r);
            end
        end
    end

endmodule

// File: rtl/pic_cmd_decode.sv
// Module: pic_cmd_decode
// Decodes processor writes: loads the mask, keeps the ordering mode, the
// lowest-ranked level and the read selection, and emits end-of-service.
// Assumes one write per strobe cycle and LEVELS <= DW.
module pic_cmd_decode
    import pic_pkg::*;
#(
    parameter int unsigned LEVELS = 8,
    parameter int unsigned DW     = 8,
    localparam int unsigned IW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic              a0,
    input  logic [DW-1:0]     wdata,
    input  logic              svc_found,
    input  logic [IW-1:0]     svc_idx,
    output logic [LEVELS-1:0] mask,
    output prio_mode_e        mode,
    output logic [IW-1:0]     lowest,
    output logic              read_sel,
    output logic              end_service
);

    localparam logic [IW-1:0] BOTTOM = IW'(LEVELS - 1);

    logic       cmd_wr;
    logic       mask_wr;
    logic [2:0] opcode;
    logic       pin_ok;

    // Split a qualified write into the command and mask paths.
    always_comb begin
        cmd_wr      = cs && wr && !a0;
        mask_wr     = cs && wr && a0;
        opcode      = wdata[DW-1 -: 3];
        end_service = cmd_wr && (opcode == OP_END_SERVICE);
        pin_ok      = int'(wdata[IW-1:0]) < LEVELS;
    end

    // Hold the mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (mask_wr) begin
            mask <= wdata[LEVELS-1:0];
        end
    end

    // Hold the ordering mode, the bottom level and the read selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= PM_FIXED;
            lowest   <= BOTTOM;
            read_sel <= READ_REQ;
        end else if (cmd_wr) begin
            case (opcode)
                OP_SET_FIXED: begin
                    mode   <= PM_FIXED;
                    lowest <= BOTTOM;
                end
                OP_SET_ROTATE: begin
                    mode   <= PM_ROTATE;
                    lowest <= BOTTOM;
                end
                OP_SET_PINNED: begin
                    if (pin_ok) begin
                        mode   <= PM_PINNED;
                        lowest <= wdata[IW-1:0];
                    end
                end
                OP_READ_SELECT: read_sel <= wdata[0];
                OP_END_SERVICE: begin
                    if (mode == PM_ROTATE && svc_found) begin
                        lowest <= svc_idx;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_fixed_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_FIXED) |-> (lowest == BOTTOM));

    assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && a0) |=> (mask == $past(wdata[LEVELS-1:0])));

    assert_rotate_on_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_service && mode == PM_ROTATE && svc_found) |=> (lowest == $past(svc_idx)));

    assert_pinned_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (end_service && mode == PM_PINNED) |=> $stable(lowest));

endmodule

// File: rtl/pic_level_regs.sv
// Module: pic_level_regs
// Keeps the request and in-service registers and the acknowledged index.
// Assumes ack_take is only high while the interrupt line is high, and that
// win_idx / svc_idx are valid whenever they are used.
module pic_level_regs #(
    parameter int unsigned LEVELS = 8,
    localparam int unsigned IW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] irq_in,
    input  logic              ack_take,
    input  logic [IW-1:0]     win_idx,
    input  logic              end_service,
    input  logic              svc_found,
    input  logic [IW-1:0]     svc_idx,
    output logic [LEVELS-1:0] req_q,
    output logic [LEVELS-1:0] svc_q,
    output logic [IW-1:0]     ack_idx
);

    localparam logic [LEVELS-1:0] ONE = {{(LEVELS-1){1'b0}}, 1'b1};

    logic [LEVELS-1:0] take_bit;
    logic [LEVELS-1:0] retire_bit;

    // One-hot vectors for the level taken and the level retired.
    always_comb begin
        take_bit   = ack_take ? (ONE << win_idx) : '0;
        retire_bit = (end_service && svc_found) ? (ONE << svc_idx) : '0;
    end

    // Latch new requests; an acknowledge clears its level in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= (req_q | irq_in) & ~take_bit;
        end
    end

    // Track levels under service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q <= '0;
        end else begin
            svc_q <= (svc_q & ~retire_bit) | take_bit;
        end
    end

    // Remember the index of the last accepted acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_idx <= '0;
        end else if (ack_take) begin
            ack_idx <= win_idx;
        end
    end

    assert_req_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_take |=> ((req_q & $past(req_q)) == $past(req_q)));

    assert_ack_moves_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> (svc_q[$past(win_idx)] && !req_q[$past(win_idx)]
                      && ack_idx == $past(win_idx)));

    assert_end_retires_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (end_service && svc_found && !ack_take) |=>
            ($countones(svc_q) + 1 == $past($countones(svc_q))));

endmodule

// File: rtl/pic_ctrl.sv
// Module: pic_ctrl (top)
// Eight-level priority interrupt controller: request latching, masking,
// three priority orderings, acknowledge handshake and a byte-wide port.
// Assumes ack is a one-cycle pulse and reads are combinational.
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned LEVELS = 8,
    parameter int unsigned DW     = 8,
    localparam int unsigned IW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic              a0,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [LEVELS-1:0] irq_in,
    input  logic              ack,
    output logic              int_out,
    output logic [IW-1:0]     ack_idx
);

    logic [LEVELS-1:0] mask;
    logic [LEVELS-1:0] req_q;
    logic [LEVELS-1:0] svc_q;
    logic [LEVELS-1:0] pending;
    prio_mode_e        mode;
    logic [IW-1:0]     lowest;
    logic              read_sel;
    logic              end_service;
    logic              req_found;
    logic [IW-1:0]     req_idx;
    logic [IW-1:0]     req_rank;
    logic              svc_found;
    logic [IW-1:0]     svc_idx;
    logic [IW-1:0]     svc_rank;
    logic              ack_take;

    pic_cmd_decode #(.LEVELS(LEVELS), .DW(DW)) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs          (cs),
        .wr          (wr),
        .a0          (a0),
        .wdata       (wdata),
        .svc_found   (svc_found),
        .svc_idx     (svc_idx),
        .mask        (mask),
        .mode        (mode),
        .lowest      (lowest),
        .read_sel    (read_sel),
        .end_service (end_service)
    );

    pic_level_regs #(.LEVELS(LEVELS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq_in),
        .ack_take    (ack_take),
        .win_idx     (req_idx),
        .end_service (end_service),
        .svc_found   (svc_found),
        .svc_idx     (svc_idx),
        .req_q       (req_q),
        .svc_q       (svc_q),
        .ack_idx     (ack_idx)
    );

    // Requests allowed into arbitration.
    always_comb pending = req_q & ~mask;

    pic_prio_pick #(.LEVELS(LEVELS)) u_pick_req (
        .vec    (pending),
        .lowest (lowest),
        .found  (req_found),
        .idx    (req_idx),
        .rank   (req_rank)
    );

    pic_prio_pick #(.LEVELS(LEVELS)) u_pick_svc (
        .vec    (svc_q),
        .lowest (lowest),
        .found  (svc_found),
        .idx    (svc_idx),
        .rank   (svc_rank)
    );

    // Interrupt only when the best request outranks all work in service.
    always_comb begin
        int_out  = req_found && (!svc_found || (req_rank < svc_rank));
        ack_take = ack && int_out;
    end

    // Read mux: mask on a0 high, else the selected level register.
    always_comb begin
        rdata = '0;
        if (cs) begin
            if (a0) begin
                rdata[LEVELS-1:0] = mask;
            end else if (read_sel == READ_SVC) begin
                rdata[LEVELS-1:0] = svc_q;
            end else begin
                rdata[LEVELS-1:0] = req_q;
            end
        end
    end

    assert_no_nest_same_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> !svc_q[req_idx]);

    assert_idle_ack_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out) |=> $stable(ack_idx));

    assert_mode_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_FIXED) || (mode == PM_ROTATE) || (mode == PM_PINNED));

endmodule

// File: tb/tb_pic_ctrl.sv
module tb_pic_ctrl;

    localparam int N  = 8;
    localparam int DW = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs, wr, a0, ack;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic [N-1:0]  irq_in;
    logic          int_out;
    logic [IW-1:0] ack_idx;

    always #5 clk = ~clk;

    pic_ctrl #(.LEVELS(N), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .a0(a0), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .ack(ack), .int_out(int_out),
        .ack_idx(ack_idx)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model of the controller state.
    logic [N-1:0]  m_req, m_svc, m_mask;
    int            m_lo, m_mode;
    logic [IW-1:0] m_idx;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int rank_of(int lvl);
        return (lvl + 2 * N - m_lo - 1) % N;
    endfunction

    function automatic int top_of(logic [N-1:0] v);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (v[i] && (best < 0 || rank_of(i) < rank_of(best))) best = i;
        return best;
    endfunction

    function automatic logic int_exp();
        int w = top_of(m_req & ~m_mask);
        int s = top_of(m_svc);
        if (w < 0) return 1'b0;
        return (s < 0) || (rank_of(w) < rank_of(s));
    endfunction

    task automatic wr_reg(logic addr, logic [7:0] d);
        cs = 1; wr = 1; a0 = addr; wdata = d;
        @(negedge clk);
        cs = 0; wr = 0; a0 = 0; wdata = '0;
    endtask

    task automatic rd_reg(logic addr, output logic [7:0] d);
        cs = 1; a0 = addr;
        #1 d = rdata;
        cs = 0; a0 = 0;
        #1;
    endtask

    task automatic end_svc();
        int s = top_of(m_svc);
        wr_reg(1'b0, 8'h20);
        if (s >= 0) begin
            m_svc[s] = 1'b0;
            if (m_mode == 1) m_lo = s;
        end
    endtask

    task automatic check_regs(string req);
        logic [7:0] v;
        wr_reg(1'b0, 8'h40);            // R10 select request register
        rd_reg(1'b0, v);
        chk({req, " R10 req readback"}, v, m_req);
        wr_reg(1'b0, 8'h41);            // R10 select in-service register
        rd_reg(1'b0, v);
        chk({req, " R10 svc readback"}, v, m_svc);
    endtask

    task automatic raise(logic [N-1:0] pat);
        irq_in = pat;
        @(negedge clk);
        irq_in = '0;
        m_req = m_req | pat;
    endtask

    task automatic do_ack(string req);
        logic e = int_exp();
        int   w = top_of(m_req & ~m_mask);
        chk({req, " R5 int before ack"}, int_out, e);
        ack = 1;
        @(negedge clk);
        ack = 0;
        if (e) begin
            m_req[w] = 1'b0;
            m_svc[w] = 1'b1;
            m_idx = IW'(w);
        end
        chk({req, " R6 ack_idx"}, ack_idx, m_idx);
    endtask

    task automatic drain(string req);
        for (int k = 0; k < 2 * N && (m_req & ~m_mask) != 0; k++) begin
            do_ack(req);
            end_svc();
            chk({req, " R7 int after end"}, int_out, int_exp());
        end
        check_regs(req);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] lfsr;
        cs = 0; wr = 0; a0 = 0; ack = 0; wdata = '0; irq_in = '0;
        rst_n = 0;
        m_req = '0; m_svc = '0; m_mask = '0; m_lo = N - 1; m_mode = 0; m_idx = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1 int_out", int_out, 0);
        chk("R1 ack_idx", ack_idx, 0);
        rd_reg(1'b1, v);
        chk("R1 mask", v, 0);
        rd_reg(1'b0, v);
        chk("R1 default read is request reg", v, 0);
        check_regs("R1");

        // R2 sticky request latch
        raise(8'h24);
        repeat (3) @(negedge clk);
        rd_reg(1'b0, v);   // select is still the in-service register
        chk("R2 svc untouched", v, 0);
        check_regs("R2");
        chk("R2 int", int_out, 1);
        drain("R2");

        // R4 fixed ordering, exhaustive over request patterns
        for (int p = 1; p < 256; p++) begin
            raise(N'(p));
            drain("R4 fixed");
        end

        // R6 ack with nothing to take
        ack = 1;
        @(negedge clk);
        ack = 0;
        chk("R6 idle ack idx", ack_idx, m_idx);
        check_regs("R6 idle");

        // R5 nesting
        raise(8'h20);
        do_ack("R5");
        raise(8'h40);
        chk("R5 lower blocked", int_out, 0);
        raise(8'h08);
        chk("R5 higher passes", int_out, 1);
        do_ack("R5");
        chk("R5 after nested ack", int_out, int_exp());
        end_svc();
        chk("R5 after first end", int_out, 0);
        end_svc();
        chk("R5 after second end", int_out, 1);
        drain("R5");

        // R3 mask sweep
        raise(8'hFF);
        for (int m = 0; m < 256; m++) begin
            wr_reg(1'b1, 8'(m));
            m_mask = N'(m);
            rd_reg(1'b1, v);
            chk("R3 mask readback", v, m);
            chk("R3 int under mask", int_out, (m != 255));
        end
        check_regs("R3 masked kept");
        wr_reg(1'b1, 8'h0F);
        m_mask = 8'h0F;
        drain("R3 partial mask");
        wr_reg(1'b1, 8'h00);
        m_mask = '0;
        drain("R3 unmask");

        // R11 cs low
        cs = 0; wr = 1; a0 = 1; wdata = 8'h55;
        @(negedge clk);
        wr = 0; a0 = 0; wdata = '0;
        #1 chk("R11 rdata idle", rdata, 0);
        rd_reg(1'b1, v);
        chk("R11 mask unchanged", v, 0);

        // R12 undefined opcodes with a level in service
        raise(8'h04);
        do_ack("R12");
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b0, 8'hC0);
        wr_reg(1'b0, 8'hE0);
        chk("R12 int unchanged", int_out, 0);
        check_regs("R12");
        end_svc();
        check_regs("R12 cleanup");

        // R8 rotating ordering
        wr_reg(1'b0, 8'h80);
        m_mode = 1; m_lo = N - 1;
        lfsr = 8'hA5;
        for (int t = 0; t < 96; t++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            raise(lfsr | 8'h01);
            drain("R8 rotate");
        end

        // R9 pinned ordering for every bottom level
        for (int lo = 0; lo < N; lo++) begin
            wr_reg(1'b0, 8'hA0 | 8'(lo));
            m_mode = 2; m_lo = lo;
            for (int t = 0; t < 32; t++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                raise(lfsr);
                drain("R9 pinned");
            end
        end

        // R4 back to fixed
        wr_reg(1'b0, 8'h60);
        m_mode = 0; m_lo = N - 1;
        raise(8'h81);
        drain("R4 refixed");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule